// File: doc/BRIEF.md
# Palette RAM Host Port

This block is the processor-facing side of a colour lookup palette that holds 256 entries, each made of three 10-bit components (red, green, blue). A host reaches it over an 8-bit data bus. Each bus cycle is a one-clock strobe together with a read/write flag and a two-bit target select. The select picks one of four targets: an 8-bit address register, the palette RAM, a small bank of control registers reached indirectly through the address register, or a mode register.

A 10-bit component does not fit on the 8-bit bus, so each one takes two cycles: the upper eight bits first, then the lower two bits. A full palette entry therefore takes six cycles in the fixed order red, green, blue.
- **Writes:** after the sixth write cycle the assembled entry is stored at the address register, and the address register increments.
- **Reads:** the six cycles return an entry in the same order. The entry is captured whole on the first cycle, so all six bytes come from one consistent entry. The address register advances after the sixth cycle.

Writing the address register restarts the six-step sequence, so the host can always begin a clean triple. The pixel-side lookup and the converters are outside this block.

Top module: `palette_host_port`

## Requirements
- R1: `bus_sel` selects the target of a strobed cycle: 00 = address register, 01 = palette RAM, 10 = control bank, 11 = mode register. A write to the address register or the mode register is returned unchanged by a later read of the same target.
- R2: A control-bank access reaches the control register whose index equals the current address register value. Indices 0, 1 and 2 exist. Writes to any other index are ignored, and reads of any other index return 0x00.
- R3: After reset:
  - the address register reads 0x00;
  - the mode register reads 0xFF;
  - control register 0 reads 0x00;
  - control registers 1 and 2 read 0xFF;
  - the palette sequence starts at red-high.
- R4: Palette writes are taken in the order red-high, red-low, green-high, green-low, blue-high, blue-low. A high cycle carries component bits 9..2 on data bits 7..0. A low cycle carries bits 1..0 on data bits 1..0, and data bits 7..2 of a low cycle are ignored. The entry at the address register is written when the sixth cycle is taken.
- R5: After the sixth palette write cycle the address register increments by one, wrapping from 0xFF to 0x00.
- R6: Palette reads return the entry at the address register in the same six-cycle order and packing as R4, and the address register increments by one (with wrap) after the sixth read cycle.
- R7: On a low-part palette read cycle, `bus_rdata` bits 7..2 are zero.
- R8: Writing the address register returns the palette sequence to red-high, discarding any partly written entry.
- R9: `bus_rdata` is updated at the clock edge that takes a read strobe and keeps its value until the next read strobe.
- R10: A cycle with `bus_stb` low changes no register, whatever the other bus inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every bus cycle is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | One-cycle strobe qualifying a bus cycle |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_sel | input | 2 | Target select (see R1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Every result in this block is due exactly one clock edge after the strobe that causes it:
- read data is registered at the edge that takes the read strobe;
- the palette entry commit and the address increment also happen at that edge.

The bench therefore drives each cycle at a falling edge, lets the next rising edge take it, and reads `bus_rdata` at the falling edge after that. The effect of a write is always observed through a later strobed read, never through internal state. Multi-cycle behaviour (the six-step order, the address wrap, the sequence restart) is checked by reading back the address register or the palette after the whole sequence has been issued.

// File: rtl/palhost_pkg.sv
package palhost_pkg;
    localparam int BUS_W    = 8;
    localparam int COMP_W   = 10;
    localparam int ADDR_W   = 8;
    localparam int LO_W     = COMP_W - BUS_W;
    localparam int STEPS    = 6;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int NUM_CTRL = 3;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_PAL  = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_MODE = 2'b11
    } sel_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] blue;
    } rgb_t;

    localparam int RGB_W = $bits(rgb_t);

    function automatic logic [COMP_W-1:0] rgb_pick(rgb_t c, logic [1:0] idx);
        case (idx)
            2'd0:    return c.red;
            2'd1:    return c.green;
            default: return c.blue;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_reset(int idx);
        return (idx == 0) ? '0 : '1;
    endfunction

    function automatic logic [BUS_W-1:0] bus_slice(logic [COMP_W-1:0] v, logic high);
        return high ? v[COMP_W-1:LO_W] : {{(BUS_W-LO_W){1'b0}}, v[LO_W-1:0]};
    endfunction
endpackage

// File: rtl/palhost_ram.sv
module palhost_ram
    import palhost_pkg::*;
#(
    parameter int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  rgb_t              wdata,
    output rgb_t              rdata
);
    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/palhost_regs.sv
module palhost_regs
    import palhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              rd,
    input  sel_e              sel,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] idx,
    output logic [BUS_W-1:0]  mode_q,
    output logic [BUS_W-1:0]  ctrl_rd
);
    logic [BUS_W-1:0] ctrl_q [NUM_CTRL];
    logic             wr_mode, wr_ctrl;

    assign wr_mode = stb && !rd && (sel == SEL_MODE);
    assign wr_ctrl = stb && !rd && (sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '1;
            for (int i = 0; i < NUM_CTRL; i++) ctrl_q[i] <= ctrl_reset(i);
        end else begin
            if (wr_mode) mode_q <= wdata;
            for (int i = 0; i < NUM_CTRL; i++)
                if (wr_ctrl && idx == ADDR_W'(i)) ctrl_q[i] <= wdata;
        end
    end

    always_comb begin
        ctrl_rd = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (idx == ADDR_W'(i)) ctrl_rd = ctrl_q[i];
    end

    // R3
    mode_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == '1 && ctrl_q[0] == '0));
    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(mode_q));
endmodule

// File: rtl/palhost_seq.sv
module palhost_seq
    import palhost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              rd,
    input  sel_e              sel,
    input  logic [BUS_W-1:0]  wdata,
    input  rgb_t              ram_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [STEP_W-1:0] step_q,
    output logic              ram_we,
    output rgb_t              ram_wdata,
    output logic [BUS_W-1:0]  rd_byte
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    logic              pal_acc, addr_wr, last_step, hi_step;
    logic [1:0]        comp_idx;
    logic [BUS_W-1:0]  hold_hi;
    logic [COMP_W-1:0] red_acc, green_acc;
    rgb_t              snap, rd_src;

    assign pal_acc   = stb && (sel == SEL_PAL);
    assign addr_wr   = stb && !rd && (sel == SEL_ADDR);
    assign last_step = (step_q == LAST);
    assign hi_step   = !step_q[0];
    assign comp_idx  = 2'(step_q >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            step_q    <= '0;
            hold_hi   <= '0;
            red_acc   <= '0;
            green_acc <= '0;
            snap      <= '0;
        end else if (addr_wr) begin
            addr_q <= wdata;
            step_q <= '0;
        end else if (pal_acc) begin
            step_q <= last_step ? '0 : step_q + 1'b1;
            if (last_step) addr_q <= addr_q + 1'b1;
            if (rd) begin
                if (step_q == '0) snap <= ram_rdata;
            end else if (hi_step) begin
                hold_hi <= wdata;
            end else begin
                case (comp_idx)
                    2'd0:    red_acc   <= {hold_hi, wdata[LO_W-1:0]};
                    2'd1:    green_acc <= {hold_hi, wdata[LO_W-1:0]};
                    default: ;
                endcase
            end
        end
    end

    assign ram_we    = pal_acc && !rd && last_step;
    assign ram_wdata = '{red: red_acc, green: green_acc, blue: {hold_hi, wdata[LO_W-1:0]}};

    assign rd_src  = (step_q == '0) ? ram_rdata : snap;
    assign rd_byte = bus_slice(rgb_pick(rd_src, comp_idx), hi_step);

    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST);
    // R8
    addr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> (step_q == '0));
    // R5
    wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)) && (step_q == '0));
    // R6
    rd_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (pal_acc && rd && last_step) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(addr_q) && $stable(step_q)));
endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
    import palhost_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_stb,
    input  logic             bus_rd,
    input  logic [1:0]       bus_sel,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    sel_e              sel;
    logic [ADDR_W-1:0] addr_q;
    logic [STEP_W-1:0] step_q;
    logic              ram_we;
    rgb_t              ram_wdata, ram_rdata;
    logic [BUS_W-1:0]  pal_byte, mode_q, ctrl_rd, rd_next;

    assign sel = sel_e'(bus_sel);

    palhost_seq u_seq (
        .clk(clk), .rst(rst), .stb(bus_stb), .rd(bus_rd), .sel(sel),
        .wdata(bus_wdata), .ram_rdata(ram_rdata), .addr_q(addr_q),
        .step_q(step_q), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .rd_byte(pal_byte)
    );

    palhost_ram u_ram (
        .clk(clk), .we(ram_we), .addr(addr_q),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    palhost_regs u_regs (
        .clk(clk), .rst(rst), .stb(bus_stb), .rd(bus_rd), .sel(sel),
        .wdata(bus_wdata), .idx(addr_q), .mode_q(mode_q), .ctrl_rd(ctrl_rd)
    );

    always_comb begin
        case (sel)
            SEL_ADDR: rd_next = addr_q;
            SEL_PAL:  rd_next = pal_byte;
            SEL_CTRL: rd_next = ctrl_rd;
            default:  rd_next = mode_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  bus_rdata <= '0;
        else if (bus_stb && bus_rd) bus_rdata <= rd_next;
    end

    // R7
    low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_rd && sel == SEL_PAL && step_q[0]) |=> (bus_rdata[BUS_W-1:LO_W] == '0));
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !(bus_stb && bus_rd)) |=> $stable(bus_rdata));
endmodule

// File: tb/palette_host_port_tb.sv
module palette_host_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_stb = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_sel = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    palette_host_port u_dut (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // vector: [19] rd, [18:17] sel, [16:9] data, [8] check, [7:0] expected
    localparam int NV = 24;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'b00, 8'h10, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'hAB, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'hFE, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'h12, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'h01, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'h34, 1'b0, 8'h00},
        {1'b0, 2'b01, 8'h03, 1'b0, 8'h00},
        {1'b1, 2'b00, 8'h00, 1'b1, 8'h11},
        {1'b0, 2'b00, 8'h10, 1'b0, 8'h00},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'hAB},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'h02},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'h12},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'h01},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'h34},
        {1'b1, 2'b01, 8'h00, 1'b1, 8'h03},
        {1'b1, 2'b00, 8'h00, 1'b1, 8'h11},
        {1'b0, 2'b11, 8'h5A, 1'b0, 8'h00},
        {1'b1, 2'b11, 8'h00, 1'b1, 8'h5A},
        {1'b0, 2'b00, 8'h01, 1'b0, 8'h00},
        {1'b0, 2'b10, 8'h3C, 1'b0, 8'h00},
        {1'b0, 2'b00, 8'h00, 1'b0, 8'h00},
        {1'b1, 2'b10, 8'h00, 1'b1, 8'h00},
        {1'b0, 2'b00, 8'h01, 1'b0, 8'h00},
        {1'b1, 2'b10, 8'h00, 1'b1, 8'h3C}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // one strobed cycle; rdata is sampled at the falling edge after the taking edge
    task automatic cyc(input logic rd, input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_rd = rd; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_stb = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [1:0] sel, input logic [7:0] exp);
        cyc(1'b1, sel, 8'h00);
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R3 reset values
        rchk("R3 addr", 2'b00, 8'h00);
        rchk("R3 mode", 2'b11, 8'hFF);
        rchk("R3 ctrl0", 2'b10, 8'h00);
        cyc(1'b0, 2'b00, 8'h01); rchk("R3 ctrl1", 2'b10, 8'hFF);
        cyc(1'b0, 2'b00, 8'h02); rchk("R3 ctrl2", 2'b10, 8'hFF);
        // R2 missing index
        cyc(1'b0, 2'b00, 8'h03); cyc(1'b0, 2'b10, 8'h77);
        rchk("R2 absent index", 2'b10, 8'h00);

        // table: R1 R2 R4 R5 R6 R7
        do_reset();
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][19], VEC[i][18:17], VEC[i][16:9]);
            if (VEC[i][8]) check($sformatf("R1/R2/R4/R6/R7 vec%0d", i), bus_rdata, VEC[i][7:0]);
        end

        // R5 wrap on write
        cyc(1'b0, 2'b00, 8'hFF);
        cyc(1'b0, 2'b01, 8'hC3); cyc(1'b0, 2'b01, 8'h01);
        cyc(1'b0, 2'b01, 8'h5C); cyc(1'b0, 2'b01, 8'h02);
        cyc(1'b0, 2'b01, 8'h80); cyc(1'b0, 2'b01, 8'h03);
        rchk("R5 wrap", 2'b00, 8'h00);
        // R6 wrap on read, R7 low bytes
        cyc(1'b0, 2'b00, 8'hFF);
        rchk("R6 red hi", 2'b01, 8'hC3);
        rchk("R7 red lo", 2'b01, 8'h01);
        rchk("R6 green hi", 2'b01, 8'h5C);
        rchk("R7 green lo", 2'b01, 8'h02);
        rchk("R6 blue hi", 2'b01, 8'h80);
        rchk("R7 blue lo", 2'b01, 8'h03);
        rchk("R6 wrap", 2'b00, 8'h00);

        // R8 restart discards partial entry
        cyc(1'b0, 2'b00, 8'h20);
        cyc(1'b0, 2'b01, 8'h99); cyc(1'b0, 2'b01, 8'h01); cyc(1'b0, 2'b01, 8'h88);
        cyc(1'b0, 2'b00, 8'h20);
        cyc(1'b0, 2'b01, 8'h11); cyc(1'b0, 2'b01, 8'h00);
        cyc(1'b0, 2'b01, 8'h22); cyc(1'b0, 2'b01, 8'h01);
        cyc(1'b0, 2'b01, 8'h33); cyc(1'b0, 2'b01, 8'h02);
        rchk("R8 addr after triple", 2'b00, 8'h21);
        cyc(1'b0, 2'b00, 8'h20);
        rchk("R8 red hi", 2'b01, 8'h11);
        rchk("R8 red lo", 2'b01, 8'h00);
        rchk("R8 green hi", 2'b01, 8'h22);

        // R10 unstrobed cycles change nothing
        cyc(1'b0, 2'b00, 8'h40);
        @(negedge clk);
        bus_stb = 1'b0; bus_rd = 1'b0; bus_sel = 2'b11; bus_wdata = 8'h00;
        @(negedge clk); bus_sel = 2'b00; bus_wdata = 8'h77;
        @(negedge clk); bus_sel = 2'b01;
        @(negedge clk);
        rchk("R10 mode kept", 2'b11, 8'h5A);
        rchk("R10 addr kept", 2'b00, 8'h40);

        // R9 rdata holds without a read strobe
        cyc(1'b0, 2'b11, 8'h66);
        check("R9 hold after write", bus_rdata, 8'h40);
        @(negedge clk); @(negedge clk);
        check("R9 hold idle", bus_rdata, 8'h40);
        rchk("R1 mode readback", 2'b11, 8'h66);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule